// File: doc/BRIEF.md
# Interrupt Status Aggregation Unit

This block collects event pulses from a network controller's transmit and receive datapaths into a 32-bit sticky status register. It combines those bits with a 32-bit enable register into two summary bits, one per direction, which drive a transmit interrupt line and a receive interrupt line. A small general status register records when transmit or receive was switched off while running. Software reaches all three registers through a plain 32-bit register bus. The bus has a write strobe, a word address and a combinational read port.

The receive half of the status register is bits 15:0 and the transmit half is bits 31:16. Each summary bit is a status bit in its own right. It is recomputed only when one of these happens: any bit of its half is set by an event, software writes the status register, or software writes the enable register. Only three sources per direction take part in the summary. The output line for a direction rises only when the summary bit and the enable bit at the same position are both 1. A soft reset pulse clears all status and halt flags and holds the enable register.

Top module: `intr_agg`

## Requirements
- R1: An event pulse on a non-summary bit sets that status bit on the next clock edge. The bit then stays at 1 until software clears it or a soft reset occurs.
- R2: The receive summary is status bit 0. When recomputed, it becomes 1 if any receive source (good frame bit 4, descriptor unavailable bit 10, bus error bit 14) is 1 together with its enable bit. Otherwise it becomes 0.
- R3: The transmit summary is status bit 16. When recomputed, it becomes 1 if any transmit source (frame sent bit 18, descriptor unavailable bit 23, bus error bit 24) is 1 together with its enable bit. Otherwise it becomes 0.
- R4: `irq_rx` equals status bit 0 AND enable bit 0. `irq_tx` equals status bit 16 AND enable bit 16.
- R5: A write to the status register (address 0x04) clears exactly the bits written as 1 and recomputes both summaries. When an event sets a bit that the same write clears, the bit stays set.
- R6: The enable register (address 0x00) reads back the value last written, and a write to it recomputes both summaries in the same edge.
- R7: A 1-to-0 change on `tx_on` sets halt flag bit 3, and a 1-to-0 change on `rx_on` sets halt flag bit 2, in the general status register (address 0x08). A 0-to-1 change on either input sets nothing.
- R8: A write to the general status register clears exactly the halt flags written as 1. A halt event in the same cycle wins over the clear. The other bits of this register read as 0.
- R9: A cycle with `soft_rst` high clears the status register and the halt flags, and events in that cycle are discarded. Both interrupt lines are low after that edge, and the enable register is kept.
- R10: Reads of any address other than 0x00, 0x04 and 0x08 return 0, and writes to them change no register.
- R11: Event pulses on the summary positions (bits 0 and 16) are ignored and trigger no recomputation.
- R12: After the reset input is released, all three registers read 0 and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| soft_rst | input | 1 | Synchronous soft reset pulse |
| evt_set | input | 32 | One-cycle event pulses, one per status bit |
| tx_on | input | 1 | Transmit-running level |
| rx_on | input | 1 | Receive-running level |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from address |
| irq_tx | output | 1 | Transmit interrupt line |
| irq_rx | output | 1 | Receive interrupt line |

## Verification
The collision that matters is an event pulse arriving in the same cycle as a software write-one-to-clear of the same bit. This applies to the status register and to the halt flags. The bench provokes it by driving the event (or the falling `tx_on`) and the bus write in one cycle. It then reads the register one edge later and expects the bit still set, and expects the summary to reflect the surviving source. A second overlap, an enable write in the same cycle as a receive event, is judged by the summary and `irq_rx` after that single edge.

// File: rtl/intr_agg_pkg.sv
`timescale 1ns/1ps
package intr_agg_pkg;

  localparam int REG_W  = 32;
  localparam int HALF_W = 16;
  localparam int N_HALF = 2;

  // Receive half (bits 15:0)
  localparam int RX_SUM_BIT    = 0;
  localparam int RX_GOOD_BIT   = 4;
  localparam int RX_NODESC_BIT = 10;
  localparam int RX_BUSERR_BIT = 14;
  // Transmit half (bits 31:16)
  localparam int TX_SUM_BIT    = 16;
  localparam int TX_DONE_BIT   = 18;
  localparam int TX_NODESC_BIT = 23;
  localparam int TX_BUSERR_BIT = 24;

  localparam logic [REG_W-1:0] RX_SRC_MASK =
    (REG_W'(1) << RX_GOOD_BIT) | (REG_W'(1) << RX_NODESC_BIT) | (REG_W'(1) << RX_BUSERR_BIT);
  localparam logic [REG_W-1:0] TX_SRC_MASK =
    (REG_W'(1) << TX_DONE_BIT) | (REG_W'(1) << TX_NODESC_BIT) | (REG_W'(1) << TX_BUSERR_BIT);
  localparam logic [REG_W-1:0] SUM_MASK =
    (REG_W'(1) << RX_SUM_BIT) | (REG_W'(1) << TX_SUM_BIT);

  // General status halt flags
  localparam int GS_RXHALT_BIT = 2;
  localparam int GS_TXHALT_BIT = 3;
  localparam logic [REG_W-1:0] GS_MASK =
    (REG_W'(1) << GS_RXHALT_BIT) | (REG_W'(1) << GS_TXHALT_BIT);

  // Register byte offsets
  localparam int OFS_ENABLE = 'h00;
  localparam int OFS_STATUS = 'h04;
  localparam int OFS_GSTAT  = 'h08;

  typedef struct packed {
    logic en_wr;
    logic st_wr;
    logic gs_wr;
  } wr_hit_t;

  // Source mask of half h (0 = receive, 1 = transmit)
  function automatic logic [REG_W-1:0] src_mask_of(input int h);
    return (h == 1) ? TX_SRC_MASK : RX_SRC_MASK;
  endfunction

  // Summary bit position of half h
  function automatic int sum_pos_of(input int h);
    return (h == 1) ? TX_SUM_BIT : RX_SUM_BIT;
  endfunction

  // Any enabled source present
  function automatic logic summary_of(input logic [REG_W-1:0] st,
                                      input logic [REG_W-1:0] en,
                                      input logic [REG_W-1:0] mask);
    return |(st & en & mask);
  endfunction

  // Clear then set: a set in the same cycle wins
  function automatic logic [REG_W-1:0] clr_then_set(input logic [REG_W-1:0] cur,
                                                    input logic [REG_W-1:0] clr,
                                                    input logic [REG_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/intr_agg_regbus.sv
`timescale 1ns/1ps
module intr_agg_regbus
  import intr_agg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  enable_q,
  input  logic [REG_W-1:0]  status_q,
  input  logic [REG_W-1:0]  gstat_q,
  output wr_hit_t           wr_hit,
  output logic              addr_known,
  output logic [REG_W-1:0]  bus_rdata
);

  logic sel_en, sel_st, sel_gs;

  assign sel_en = (bus_addr == ADDR_W'(OFS_ENABLE));
  assign sel_st = (bus_addr == ADDR_W'(OFS_STATUS));
  assign sel_gs = (bus_addr == ADDR_W'(OFS_GSTAT));

  assign addr_known = sel_en | sel_st | sel_gs;

  assign wr_hit.en_wr = bus_wr & sel_en;
  assign wr_hit.st_wr = bus_wr & sel_st;
  assign wr_hit.gs_wr = bus_wr & sel_gs;

  always_comb begin
    bus_rdata = '0;
    if (sel_en) bus_rdata = enable_q;
    if (sel_st) bus_rdata = status_q;
    if (sel_gs) bus_rdata = gstat_q & GS_MASK;
  end

endmodule

// File: rtl/intr_agg_status.sv
`timescale 1ns/1ps
module intr_agg_status
  import intr_agg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic [REG_W-1:0] evt_set,
  input  logic             st_wr,
  input  logic             en_wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] status_q,
  output logic [REG_W-1:0] enable_q,
  output logic [REG_W-1:0] evt_eff
);

  logic [REG_W-1:0]  en_n;
  logic [REG_W-1:0]  clr_vec;
  logic [REG_W-1:0]  st_base;
  logic [REG_W-1:0]  st_n;
  logic [N_HALF-1:0] half_recalc;
  logic [N_HALF-1:0] half_sum;

  // Summary positions are computed, never set by events
  assign evt_eff = evt_set & ~SUM_MASK;
  assign en_n    = en_wr ? wdata : enable_q;
  assign clr_vec = st_wr ? wdata : '0;
  assign st_base = clr_then_set(status_q, clr_vec, evt_eff);

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    assign half_recalc[h] = (|evt_eff[h*HALF_W +: HALF_W]) | st_wr | en_wr;
    assign half_sum[h]    = summary_of(st_base, en_n, src_mask_of(h));
  end

  always_comb begin
    st_n = st_base;
    for (int h = 0; h < N_HALF; h++) begin
      st_n[sum_pos_of(h)] = half_recalc[h] ? half_sum[h] : status_q[sum_pos_of(h)];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      enable_q <= en_n;
      if (soft_rst) status_q <= '0;
      else          status_q <= st_n;
    end
  end

endmodule

// File: rtl/intr_agg_halt.sv
`timescale 1ns/1ps
module intr_agg_halt
  import intr_agg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             tx_on,
  input  logic             rx_on,
  input  logic             gs_wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] gstat_q,
  output logic             tx_off_evt,
  output logic             rx_off_evt
);

  logic             tx_on_q, rx_on_q;
  logic [REG_W-1:0] halt_set;
  logic [REG_W-1:0] halt_clr;

  assign tx_off_evt = tx_on_q & ~tx_on;
  assign rx_off_evt = rx_on_q & ~rx_on;

  always_comb begin
    halt_set = '0;
    halt_set[GS_TXHALT_BIT] = tx_off_evt;
    halt_set[GS_RXHALT_BIT] = rx_off_evt;
  end

  assign halt_clr = gs_wr ? (wdata & GS_MASK) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_on_q <= 1'b0;
      rx_on_q <= 1'b0;
      gstat_q <= '0;
    end else begin
      tx_on_q <= tx_on;
      rx_on_q <= rx_on;
      if (soft_rst) gstat_q <= '0;
      else          gstat_q <= clr_then_set(gstat_q, halt_clr, halt_set) & GS_MASK;
    end
  end

endmodule

// File: rtl/intr_agg.sv
`timescale 1ns/1ps
module intr_agg
  import intr_agg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [31:0]       evt_set,
  input  logic              tx_on,
  input  logic              rx_on,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_tx,
  output logic              irq_rx
);

  wr_hit_t          wr_hit;
  logic             addr_known;
  logic             en_wr_hit, st_wr_hit, gs_wr_hit;
  logic [REG_W-1:0] status_q, enable_q, gstat_q, evt_eff;
  logic             tx_off_evt, rx_off_evt;

  assign en_wr_hit = wr_hit.en_wr;
  assign st_wr_hit = wr_hit.st_wr;
  assign gs_wr_hit = wr_hit.gs_wr;

  intr_agg_regbus #(.ADDR_W(ADDR_W)) u_bus (
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .enable_q   (enable_q),
    .status_q   (status_q),
    .gstat_q    (gstat_q),
    .wr_hit     (wr_hit),
    .addr_known (addr_known),
    .bus_rdata  (bus_rdata)
  );

  intr_agg_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .evt_set  (evt_set),
    .st_wr    (st_wr_hit),
    .en_wr    (en_wr_hit),
    .wdata    (bus_wdata),
    .status_q (status_q),
    .enable_q (enable_q),
    .evt_eff  (evt_eff)
  );

  intr_agg_halt u_halt (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .tx_on      (tx_on),
    .rx_on      (rx_on),
    .gs_wr      (gs_wr_hit),
    .wdata      (bus_wdata),
    .gstat_q    (gstat_q),
    .tx_off_evt (tx_off_evt),
    .rx_off_evt (rx_off_evt)
  );

  assign irq_tx = status_q[TX_SUM_BIT] & enable_q[TX_SUM_BIT];
  assign irq_rx = status_q[RX_SUM_BIT] & enable_q[RX_SUM_BIT];

endmodule

// File: rtl/intr_agg_chk.sv
`timescale 1ns/1ps
module intr_agg_chk
  import intr_agg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic [31:0]      evt_set,
  input logic [31:0]      bus_rdata,
  input logic             irq_tx,
  input logic             irq_rx,
  input logic             addr_known,
  input logic             en_wr_hit,
  input logic             st_wr_hit,
  input logic [REG_W-1:0] status_q,
  input logic [REG_W-1:0] enable_q,
  input logic [REG_W-1:0] gstat_q,
  input logic [REG_W-1:0] evt_eff,
  input logic             tx_off_evt,
  input logic             rx_off_evt
);

  // R1
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !st_wr_hit) |=>
      ((status_q & $past(status_q & ~SUM_MASK)) == $past(status_q & ~SUM_MASK)));

  // R2
  rx_sum_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !en_wr_hit && (|(evt_set & enable_q & RX_SRC_MASK))) |=> status_q[RX_SUM_BIT]);

  // R3
  tx_sum_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !en_wr_hit && (|(evt_set & enable_q & TX_SRC_MASK))) |=> status_q[TX_SUM_BIT]);

  // R4
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_q[TX_SUM_BIT] |-> !irq_tx) and (!enable_q[RX_SUM_BIT] |-> !irq_rx));

  // R5
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr_hit && !soft_rst) |=> ((status_q & $past(evt_eff)) == $past(evt_eff)));

  // R7
  tx_halt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_off_evt && !soft_rst) |=> gstat_q[GS_TXHALT_BIT]);

  // R7
  rx_halt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_off_evt && !soft_rst) |=> gstat_q[GS_RXHALT_BIT]);

  // R9
  soft_reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (status_q == '0 && gstat_q == '0 && !irq_tx && !irq_rx));

  // R10
  unknown_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_known |-> (bus_rdata == '0));

endmodule

bind intr_agg intr_agg_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .soft_rst   (soft_rst),
  .evt_set    (evt_set),
  .bus_rdata  (bus_rdata),
  .irq_tx     (irq_tx),
  .irq_rx     (irq_rx),
  .addr_known (addr_known),
  .en_wr_hit  (en_wr_hit),
  .st_wr_hit  (st_wr_hit),
  .status_q   (status_q),
  .enable_q   (enable_q),
  .gstat_q    (gstat_q),
  .evt_eff    (evt_eff),
  .tx_off_evt (tx_off_evt),
  .rx_off_evt (rx_off_evt)
);

// File: tb/sim_intr_agg.sv
`timescale 1ns/1ps
module sim_intr_agg;

  localparam int AW = 8;
  localparam logic [7:0] A_EN = 8'h00, A_ST = 8'h04, A_GS = 8'h08;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic [31:0] evt_set = '0;
  logic        tx_on = 1'b0, rx_on = 1'b0;
  logic        bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_tx, irq_rx;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  intr_agg #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .evt_set(evt_set),
    .tx_on(tx_on), .rx_on(rx_on), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  // Stimulus and expected status / {irq_tx, irq_rx} after one edge
  typedef struct packed {
    logic [31:0] evt;
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp_st;
    logic [1:0]  exp_irq;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 1'b1, 8'h00, 32'h0000_0011, 32'h0000_0000, 2'b00},
    '{32'h0000_0010, 1'b0, 8'h00, 32'h0000_0000, 32'h0000_0011, 2'b01},
    '{32'h0004_0000, 1'b0, 8'h00, 32'h0000_0000, 32'h0004_0011, 2'b01},
    '{32'h0000_0000, 1'b1, 8'h00, 32'h0005_0011, 32'h0005_0011, 2'b11},
    '{32'h0000_0000, 1'b1, 8'h04, 32'h0000_0010, 32'h0005_0000, 2'b10},
    '{32'h0000_0020, 1'b1, 8'h04, 32'h0004_0000, 32'h0000_0020, 2'b00},
    '{32'h0001_0001, 1'b0, 8'h00, 32'h0000_0000, 32'h0000_0020, 2'b00},
    '{32'h0000_4000, 1'b1, 8'h00, 32'h0000_0001, 32'h0000_4020, 2'b00},
    '{32'h0000_0000, 1'b1, 8'h00, 32'h0000_4001, 32'h0000_4021, 2'b01},
    '{32'h0000_4000, 1'b1, 8'h04, 32'h0000_4000, 32'h0000_4021, 2'b01},
    '{32'h0000_0000, 1'b1, 8'h04, 32'hFFFF_FFFF, 32'h0000_0000, 2'b00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    n_run++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  // One clock: drive, wait for the edge, settle, release pulses
  task automatic cyc(input logic [31:0] evt, input logic wr, input logic [7:0] a,
                     input logic [31:0] d);
    evt_set = evt; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    evt_set = '0; bus_wr = 1'b0; soft_rst = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R12 reset values
    rd(A_EN, v); chk("R12 enable after reset", v, 32'h0);
    rd(A_ST, v); chk("R12 status after reset", v, 32'h0);
    rd(A_GS, v); chk("R12 gstat after reset", v, 32'h0);
    chk("R12 irq after reset", {30'h0, irq_tx, irq_rx}, 32'h0);

    // Table walk: R1 R2 R3 R5 R6 R11 on status, R4 on the lines
    for (int i = 0; i < NV; i++) begin
      cyc(VECS[i].evt, VECS[i].wr, VECS[i].addr, VECS[i].data);
      rd(A_ST, v);
      chk($sformatf("R1/R2/R3/R5/R11 vector %0d status", i), v, VECS[i].exp_st);
      chk($sformatf("R4 vector %0d irq", i), {30'h0, irq_tx, irq_rx}, {30'h0, VECS[i].exp_irq});
    end
    rd(A_EN, v); chk("R6 enable readback", v, 32'h0000_4001);

    // R7 halt flags on falling edges only
    tx_on = 1'b1; cyc('0, 1'b0, A_EN, '0);
    tx_on = 1'b0; cyc('0, 1'b0, A_EN, '0);
    rd(A_GS, v); chk("R7 tx off sets bit 3", v, 32'h8);
    rx_on = 1'b1; cyc('0, 1'b0, A_EN, '0);
    rx_on = 1'b0; cyc('0, 1'b0, A_EN, '0);
    rd(A_GS, v); chk("R7 rx off sets bit 2", v, 32'hC);
    tx_on = 1'b1; cyc('0, 1'b0, A_EN, '0);
    rd(A_GS, v); chk("R7 rising edge sets nothing", v, 32'hC);

    // R8 write-one-to-clear, halt event wins
    cyc('0, 1'b1, A_GS, 32'h8);
    rd(A_GS, v); chk("R8 clear tx halt only", v, 32'h4);
    tx_on = 1'b0; cyc('0, 1'b1, A_GS, 32'h8);
    rd(A_GS, v); chk("R8 halt beats clear", v, 32'hC);
    cyc('0, 1'b1, A_GS, 32'hFFFF_FFF8);
    rd(A_GS, v); chk("R8 clear leaves rx halt, other bits zero", v, 32'h4);

    // R10 undefined address
    cyc('0, 1'b1, 8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, v); chk("R10 undefined reads zero", v, 32'h0);
    rd(A_EN, v); chk("R10 enable untouched", v, 32'h0000_4001);
    rd(A_ST, v); chk("R10 status untouched", v, 32'h0);

    // R9 soft reset beats an event, keeps enable
    cyc('0, 1'b1, A_EN, 32'h0005_0011);
    cyc(32'h0004_0010, 1'b0, A_EN, '0);
    chk("R9 precondition irq", {30'h0, irq_tx, irq_rx}, 32'h3);
    soft_rst = 1'b1; cyc(32'h0000_0010, 1'b0, A_EN, '0);
    rd(A_ST, v); chk("R9 status cleared", v, 32'h0);
    rd(A_GS, v); chk("R9 halt flags cleared", v, 32'h0);
    rd(A_EN, v); chk("R9 enable kept", v, 32'h0005_0011);
    chk("R9 irq low", {30'h0, irq_tx, irq_rx}, 32'h0);

    // R2 enable write together with receive event in one edge
    cyc(32'h0000_0400, 1'b1, A_EN, 32'h0000_0401);
    rd(A_ST, v); chk("R2 event with enable write", v, 32'h0000_0401);
    chk("R4 rx line after combined edge", {30'h0, irq_tx, irq_rx}, 32'h1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule